// File: doc/BRIEF.md
# Target Reset Line Controller

This block owns the active-low reset wire of an attached target. It never drives the wire high: it either pulls it low or lets it float, so an external pull-up or the target itself returns the line to its inactive level. Three commands start it. A reset pulse pulls the line low for a hold time and then releases it. A hold command pulls the line low and leaves it there. A release command lets the line go. After every release the block waits for the target to recover before it reports completion.

The recovery wait depends on whether the wire can be sampled. With readback enabled, the block watches the synchronised pin and finishes as soon as the pin reads high. If the pin stays low past a long limit, it stops waiting and raises a sticky timeout flag. With readback disabled, it waits a fixed blind interval. All intervals count a microsecond tick that is divided down from the system clock.

Top module: `trc_reset_ctrl`

## Requirements
- R1: After synchronous reset, `line_drive_low`, `busy`, `done` and `timed_out` are all 0.
- R2: A `cmd_pulse` accepted while idle sets `line_drive_low` and `busy` on the next cycle. It keeps the line driven for HOLD_US microsecond ticks, then clears `line_drive_low` and enters recovery.
- R3: With readback selected, recovery ends in the cycle after the synchronised pin is seen high. `done` pulses for one cycle, `busy` clears and `timed_out` stays 0.
- R4: With readback selected, if the synchronised pin is still low once POLL_LIMIT_US ticks have elapsed, recovery ends with a `done` pulse and `timed_out` set to 1. A high pin seen in that same cycle wins, and no timeout is reported.
- R5: With readback not selected, recovery ignores the pin and ends after BLIND_US ticks with a `done` pulse and `timed_out` at 0.
- R6: A `cmd_hold` accepted while idle sets `line_drive_low` and pulses `done` on the next cycle without ever raising `busy`. The line stays driven until a later pulse or release command.
- R7: A `cmd_release` accepted while idle clears `line_drive_low` and raises `busy` on the next cycle. It then runs the same recovery as R3, R4 and R5.
- R8: Commands that arrive while `busy` is 1 have no effect on any output.
- R9: When several commands are asserted in the same idle cycle, pulse takes priority over hold, and hold takes priority over release.
- R10: `pin_level` passes through a two-flop synchroniser. If the pin rises in the cycle after the line is released, `done` appears three cycles after `line_drive_low` falls.
- R11: `timed_out` stays set until the next accepted command, which clears it.
- R12: The microsecond tick occurs once every CLK_PER_US clock cycles and runs freely from reset. The readback choice is taken from `readback_en` when a pulse or release command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_pulse | input | 1 | Start a full reset pulse (hold, release, recover) |
| cmd_hold | input | 1 | Pull the line low and leave it there |
| cmd_release | input | 1 | Release the line and recover |
| readback_en | input | 1 | 1: the pin can be sampled; poll it during recovery |
| pin_level | input | 1 | Asynchronous sample of the reset wire |
| line_drive_low | output | 1 | 1 enables the open-drain pull-down |
| busy | output | 1 | A timed sequence is in progress |
| done | output | 1 | One-cycle completion strobe |
| timed_out | output | 1 | Sticky: the last polled recovery gave up |

## Verification
The hardest case to reach is a polled recovery that ends on the time limit, because it needs a target that never lets the line rise. The bench models the target as a pin that normally follows the released line and can be switched to stuck-low. Stuck-low drives the timeout, then the bench shows that the flag survives idle cycles and clears on the next command. Commands are also injected during hold and during recovery. In every cycle a behavioural model checks that they leave all outputs unchanged.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_POLL  = 2'd2,
        ST_BLIND = 2'd3
    } trc_state_e;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_PULSE   = 2'd1,
        CMD_HOLD    = 2'd2,
        CMD_RELEASE = 2'd3
    } trc_cmd_e;

    typedef struct packed {
        logic drive_low;
        logic done;
        logic timed_out;
        logic rb_mode;
    } trc_status_t;

    // Fixed priority: pulse, then hold, then release.
    function automatic trc_cmd_e pick_cmd(input logic p, input logic h, input logic r);
        if (p)      return CMD_PULSE;
        else if (h) return CMD_HOLD;
        else if (r) return CMD_RELEASE;
        else        return CMD_NONE;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/trc_tick_gen.sv
module trc_tick_gen #(
    parameter int unsigned DIV = 125
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    generate
        if (DIV > 1) begin : g_div
            always_ff @(posedge clk) begin
                if (rst)              cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                  cnt_q <= cnt_q + 1'b1;
            end
            assign tick = (cnt_q == LAST);

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R12
        end else begin : g_pass
            always_ff @(posedge clk) cnt_q <= '0;
            assign tick = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/trc_sync.sv
module trc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/trc_us_timer.sv
module trc_us_timer #(
    parameter int unsigned TW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          tick,
    output logic          expired
);
    logic [TW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                       left_q <= '0;
        else if (load)                 left_q <= load_val;
        else if (tick && left_q != '0) left_q <= left_q - 1'b1;
    end

    assign expired = (left_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired); // R12

endmodule

// File: rtl/trc_reset_ctrl.sv
module trc_reset_ctrl
    import trc_pkg::*;
#(
    parameter int unsigned CLK_PER_US    = 125,
    parameter int unsigned HOLD_US       = 50000,
    parameter int unsigned POLL_LIMIT_US = 1000000,
    parameter int unsigned BLIND_US      = 100000,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_pulse,
    input  logic cmd_hold,
    input  logic cmd_release,
    input  logic readback_en,
    input  logic pin_level,
    output logic line_drive_low,
    output logic busy,
    output logic done,
    output logic timed_out
);
    localparam int unsigned MAX_US = max3(HOLD_US, POLL_LIMIT_US, BLIND_US);
    localparam int unsigned TW     = $clog2(MAX_US + 1);
    localparam logic [TW-1:0] HOLD_V  = TW'(HOLD_US);
    localparam logic [TW-1:0] POLL_V  = TW'(POLL_LIMIT_US);
    localparam logic [TW-1:0] BLIND_V = TW'(BLIND_US);

    logic       us_tick;
    logic       pin_hi;
    logic       tmr_load;
    logic [TW-1:0] tmr_val;
    logic       tmr_expired;

    trc_state_e  state_q, state_d;
    trc_status_t stat_q, stat_d;
    trc_cmd_e    cmd;

    trc_tick_gen #(.DIV(CLK_PER_US)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (us_tick)
    );

    trc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_level),
        .q   (pin_hi)
    );

    trc_us_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (us_tick),
        .expired  (tmr_expired)
    );

    assign cmd = pick_cmd(cmd_pulse, cmd_hold, cmd_release);

    always_comb begin
        state_d        = state_q;
        stat_d         = stat_q;
        stat_d.done    = 1'b0;
        tmr_load       = 1'b0;
        tmr_val        = '0;
        unique case (state_q)
            ST_IDLE: begin
                unique case (cmd)
                    CMD_PULSE: begin
                        state_d          = ST_HOLD;
                        stat_d.drive_low = 1'b1;
                        stat_d.timed_out = 1'b0;
                        stat_d.rb_mode   = readback_en;
                        tmr_load         = 1'b1;
                        tmr_val          = HOLD_V;
                    end
                    CMD_HOLD: begin
                        stat_d.drive_low = 1'b1;
                        stat_d.done      = 1'b1;
                        stat_d.timed_out = 1'b0;
                    end
                    CMD_RELEASE: begin
                        state_d          = readback_en ? ST_POLL : ST_BLIND;
                        stat_d.drive_low = 1'b0;
                        stat_d.timed_out = 1'b0;
                        stat_d.rb_mode   = readback_en;
                        tmr_load         = 1'b1;
                        tmr_val          = readback_en ? POLL_V : BLIND_V;
                    end
                    default: ;
                endcase
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    state_d          = stat_q.rb_mode ? ST_POLL : ST_BLIND;
                    stat_d.drive_low = 1'b0;
                    tmr_load         = 1'b1;
                    tmr_val          = stat_q.rb_mode ? POLL_V : BLIND_V;
                end
            end
            ST_POLL: begin
                if (pin_hi) begin
                    state_d     = ST_IDLE;
                    stat_d.done = 1'b1;
                end else if (tmr_expired) begin
                    state_d          = ST_IDLE;
                    stat_d.done      = 1'b1;
                    stat_d.timed_out = 1'b1;
                end
            end
            ST_BLIND: begin
                if (tmr_expired) begin
                    state_d     = ST_IDLE;
                    stat_d.done = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            stat_q  <= '0;
        end else begin
            state_q <= state_d;
            stat_q  <= stat_d;
        end
    end

    assign line_drive_low = stat_q.drive_low;
    assign busy           = (state_q != ST_IDLE);
    assign done           = stat_q.done;
    assign timed_out      = stat_q.timed_out;

    AST_HOLD_PULLS_LOW: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |-> line_drive_low); // R2

    AST_RECOVERY_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POLL || state_q == ST_BLIND) |-> !line_drive_low); // R7

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R3

    AST_TIMEOUT_FROM_POLL: assert property (@(posedge clk) disable iff (rst)
        $rose(timed_out) |-> $past(state_q == ST_POLL)); // R4

    AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POLL && (cmd_pulse || cmd_hold)) |=> !line_drive_low); // R8

    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (timed_out && !cmd_pulse && !cmd_hold && !cmd_release) |=> timed_out); // R11

endmodule

// File: tb/trc_reset_ctrl_tb.sv
module trc_reset_ctrl_tb;
    localparam int DIV   = 4;
    localparam int HOLD  = 6;
    localparam int LIMIT = 10;
    localparam int BLIND = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_pulse = 1'b0, cmd_hold = 1'b0, cmd_release = 1'b0;
    logic readback_en = 1'b0;
    logic pin_level = 1'b0;
    logic line_drive_low, busy, done, timed_out;
    logic pin_stuck = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    trc_reset_ctrl #(
        .CLK_PER_US(DIV), .HOLD_US(HOLD), .POLL_LIMIT_US(LIMIT), .BLIND_US(BLIND)
    ) u_dut (
        .clk(clk), .rst(rst), .cmd_pulse(cmd_pulse), .cmd_hold(cmd_hold),
        .cmd_release(cmd_release), .readback_en(readback_en), .pin_level(pin_level),
        .line_drive_low(line_drive_low), .busy(busy), .done(done), .timed_out(timed_out)
    );

    // Target model: line follows the pull-down unless stuck low.
    always @(negedge clk) pin_level <= pin_stuck ? 1'b0 : ~line_drive_low;

    // Behavioural reference model
    int m_div, m_s1, m_s2, m_rem, m_mode, m_st;
    int m_drv, m_done, m_to;
    always @(posedge clk) begin
        int t, p, ex, ld;
        cyc++;
        if (rst) begin
            m_div = 0; m_s1 = 0; m_s2 = 0; m_rem = 0; m_mode = 0; m_st = 0;
            m_drv = 0; m_done = 0; m_to = 0;
        end else begin
            t  = (m_div == DIV - 1);
            p  = m_s2;
            ex = (m_rem == 0);
            ld = -1;
            m_done = 0;
            if (m_st == 0) begin
                if (cmd_pulse) begin
                    m_st = 1; m_drv = 1; m_to = 0; m_mode = readback_en; ld = HOLD;
                end else if (cmd_hold) begin
                    m_drv = 1; m_done = 1; m_to = 0;
                end else if (cmd_release) begin
                    m_drv = 0; m_to = 0; m_mode = readback_en;
                    m_st = readback_en ? 2 : 3; ld = readback_en ? LIMIT : BLIND;
                end
            end else if (m_st == 1) begin
                if (ex) begin
                    m_drv = 0; m_st = m_mode ? 2 : 3; ld = m_mode ? LIMIT : BLIND;
                end
            end else if (m_st == 2) begin
                if (p) begin m_st = 0; m_done = 1; end
                else if (ex) begin m_st = 0; m_done = 1; m_to = 1; end
            end else begin
                if (ex) begin m_st = 0; m_done = 1; end
            end
            if (ld >= 0) m_rem = ld;
            else if (t && m_rem > 0) m_rem--;
            m_div = t ? 0 : m_div + 1;
            m_s2 = m_s1;
            m_s1 = pin_level;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(line_drive_low == m_drv[0], "R2 model line_drive_low", line_drive_low, m_drv);
            check(busy == (m_st != 0), "R7 model busy", busy, m_st != 0);
            check(done == m_done[0], "R3 model done", done, m_done);
            check(timed_out == m_to[0], "R4 model timed_out", timed_out, m_to);
        end
    end

    task automatic issue(input logic p, input logic h, input logic r, input logic rb);
        @(negedge clk);
        cmd_pulse = p; cmd_hold = h; cmd_release = r; readback_en = rb;
        @(negedge clk);
        cmd_pulse = 0; cmd_hold = 0; cmd_release = 0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n, lowcnt;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        check(!line_drive_low && !busy && !done && !timed_out, "R1 reset state",
              {line_drive_low, busy, done, timed_out}, 0);

        // R2, R3, R10, R12: full pulse with readback, target responsive
        issue(1, 0, 0, 1);
        check(line_drive_low && busy, "R2 pulse starts", {line_drive_low, busy}, 3);
        lowcnt = 1;
        while (line_drive_low && lowcnt < 500) begin @(negedge clk); lowcnt++; end
        check(lowcnt >= (HOLD - 1) * DIV && lowcnt <= (HOLD + 1) * DIV + 1,
              "R12 hold length", lowcnt, HOLD * DIV);
        n = 0;
        while (!done && n < 50) begin @(negedge clk); n++; end
        check(n == 3, "R10 sync latency", n, 3);
        check(!timed_out && !busy, "R3 polled release no timeout", timed_out, 0);

        // R4: stuck pin -> timeout, then R11 sticky
        pin_stuck = 1;
        issue(1, 0, 0, 1);
        wait_done(n);
        check(done && timed_out, "R4 timeout flagged", timed_out, 1);
        repeat (20) @(negedge clk);
        check(timed_out == 1'b1, "R11 timeout sticky", timed_out, 1);
        pin_stuck = 0;

        // R5: no readback, blind wait; R11 cleared by command
        issue(1, 0, 0, 0);
        check(!timed_out, "R11 cleared on command", timed_out, 0);
        wait_done(n);
        check(done && !timed_out, "R5 blind recovery done", done, 1);

        // R6: hold only
        @(negedge clk);
        cmd_hold = 1;
        @(negedge clk);
        cmd_hold = 0;
        check(line_drive_low && done && !busy, "R6 hold immediate",
              {line_drive_low, done, busy}, 6);
        repeat (15) @(negedge clk);
        check(line_drive_low && !busy, "R6 line stays held", line_drive_low, 1);

        // R7 + R8: release without readback, commands injected while busy
        issue(0, 0, 1, 0);
        check(!line_drive_low && busy, "R7 release recovering", {line_drive_low, busy}, 1);
        issue(1, 1, 0, 1);
        check(!line_drive_low && busy, "R8 cmds ignored while busy", line_drive_low, 0);
        wait_done(n);
        check(done && !line_drive_low, "R7 release done", done, 1);

        // R8 during hold phase
        issue(1, 0, 0, 1);
        issue(0, 0, 1, 0);
        check(line_drive_low == 1'b1, "R8 release ignored in hold", line_drive_low, 1);
        wait_done(n);
        check(!timed_out, "R3 second polled pulse", timed_out, 0);

        // R9: all three at once -> pulse wins
        issue(1, 1, 1, 0);
        check(line_drive_low && busy, "R9 pulse has priority", {line_drive_low, busy}, 3);
        wait_done(n);
        // hold beats release
        issue(0, 1, 1, 0);
        check(line_drive_low && !busy, "R9 hold over release", {line_drive_low, busy}, 2);
        issue(0, 0, 1, 1);
        wait_done(n);
        check(done && !timed_out && !line_drive_low, "R7 polled release", done, 1);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule